// File: doc/BRIEF.md
# Byte-Accessed 16-bit Up/Down Timer Counter

This block is a 16-bit timer counter that a processor reaches through an 8-bit data bus. The count is split into a low-byte location and a high-byte location. The high byte is never reached directly. Instead, a shared 8-bit holding register sits between the bus and the upper half of the count. Reading the low byte freezes the upper half into that holding register, and writing the low byte moves the holding register and the written byte into the counter together. A full 16-bit value therefore always moves as one unit. Reads are done low byte first and writes are done high byte first.

The counter acts on qualified ticks. A 3-bit source select can stop the counter, run it from the system clock, gate it with one of four prescaler tap strobes, or step it on a synchronized falling or rising edge of an external pin. On each tick the counter clears, counts up or counts down, as the clear and direction inputs decide. A bus write to the low byte overrides any tick action in the same cycle. The top value is either all ones or a value supplied on an input, depending on the counting mode. The block shows when the count sits at its top or at zero, and it keeps a sticky overflow flag that software clears by writing a one to it.

Top module: `bytebus_tick_counter`

## Requirements
- R1: After reset the count is 0, the holding register is 0, the overflow flag is 0, read data is 0 and `at_bottom` is 1.
- R2: Bus address encoding: 0 = count low byte, 1 = holding register, 2 = flag register, 3 = unused (reads 0, writes ignored). A read presents its data on `bus_rdata` from the clock edge that samples `bus_rd`, and the data holds until the next read. A low-byte read returns count[7:0] and copies count[15:8] into the holding register on the same edge. A later high-byte read returns that captured byte, even if the counter has moved since.
- R3: A high-byte write loads only the holding register and leaves the count unchanged. A low-byte write loads the count with {holding register, written byte} on one edge.
- R4: When a low-byte write and a tick, with or without clear, fall in the same cycle, the written value wins.
- R5: With source select 0 the count holds its value, and bus accesses still work.
- R6: Source select 1 ticks every cycle. Select values 2, 3, 4 and 5 tick only in cycles where `pre_tap` bit 0, 1, 2 or 3 (respectively) is high.
- R7: Select 6 ticks once per falling edge of `ext_pin` and select 7 once per rising edge. The pin passes through two synchronizing flops, so a change made between two clock edges moves the count on the third rising clock edge after the change.
- R8: A tick with `cnt_clr` high sets the count to 0, whatever the direction.
- R9: A tick with `cnt_dir` = 0 adds 1 and wraps from TOP to 0. A tick with `cnt_dir` = 1 subtracts 1 and wraps from 0 to TOP.
- R10: Mode encoding: 0 = free-running, 1 = clear on match, 2 = up/down, 3 = same as 0. TOP is 0xFFFF in modes 0 and 3 and `match_top` in modes 1 and 2. `at_top` is high exactly when the count equals TOP, and `at_bottom` exactly when the count is 0.
- R11: In mode 1, an up tick taken while the count equals `match_top` returns the count to 0.
- R12: Setting the overflow flag depends on the mode. In modes 0, 1 and 3 it is set by an up tick taken at TOP. In mode 2 it is set by any non-clear tick that moves a nonzero count to 0. Writing address 2 with bit 0 = 1 clears the flag, and writing bit 0 = 0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R13: Reading address 2 returns {7'b0, overflow flag}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Byte location select |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data |
| clk_sel | input | 3 | Tick source select |
| pre_tap | input | 4 | Prescaler tap strobes (/8, /64, /256, /1024) |
| ext_pin | input | 1 | Asynchronous external count pin |
| cnt_dir | input | 1 | 0 counts up, 1 counts down |
| cnt_clr | input | 1 | Clear the count on a tick |
| cnt_mode | input | 2 | Counting mode |
| match_top | input | 16 | Top value for modes 1 and 2 |
| count | output | 16 | Current count |
| at_top | output | 1 | Count equals TOP |
| at_bottom | output | 1 | Count equals zero |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle, and that `ext_pin` holds a defined level from time zero. The stimulus meets both conditions. Each random cycle picks at most one bus operation, the pin is driven low before reset is released, and it only toggles on falling clock edges. Prescaler strobes, source select, mode, direction and clear are all changed freely, because the counter must handle any mix of them. Writes to the holding register mostly use small values so that clear-on-match and up/down wraps happen often.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;
    localparam logic [1:0] ADDR_LO  = 2'd0;
    localparam logic [1:0] ADDR_HI  = 2'd1;
    localparam logic [1:0] ADDR_FLG = 2'd2;

    localparam logic [2:0] SEL_OFF      = 3'd0;
    localparam logic [2:0] SEL_SYS      = 3'd1;
    localparam logic [2:0] SEL_TAP0     = 3'd2;
    localparam logic [2:0] SEL_EXT_FALL = 3'd6;
    localparam logic [2:0] SEL_EXT_RISE = 3'd7;

    typedef enum logic [1:0] {
        MODE_FREE  = 2'd0,
        MODE_MATCH = 2'd1,
        MODE_UPDN  = 2'd2,
        MODE_RSVD  = 2'd3
    } cnt_mode_e;
endpackage

// File: rtl/tcnt_tick_sel.sv
module tcnt_tick_sel
    import tcnt_pkg::*;
#(
    parameter int NTAP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      sel,
    input  logic [NTAP-1:0] taps,
    input  logic            ext_pin,
    output logic            tick
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_s;

    sync_s sync_d, sync_q;
    logic  rise, fall;

    always_comb begin
        sync_d.s1 = ext_pin;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
        rise = sync_q.s2 & ~sync_q.s3;
        fall = ~sync_q.s2 & sync_q.s3;
        tick = 1'b0;
        case (sel)
            SEL_OFF:      tick = 1'b0;
            SEL_SYS:      tick = 1'b1;
            SEL_EXT_FALL: tick = fall;
            SEL_EXT_RISE: tick = rise;
            default: begin
                for (int k = 0; k < NTAP; k++) begin
                    if (sel == 3'(SEL_TAP0 + k)) tick = taps[k];
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    // R5
    off_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_OFF) |-> !tick);

    // R7
    ext_rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_EXT_RISE && tick) |-> ($past(ext_pin, 2) && !$past(ext_pin, 3)));
endmodule

// File: rtl/tcnt_bus.sv
module tcnt_bus
    import tcnt_pkg::*;
#(
    parameter int DW = 8,
    localparam int W = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr,
    input  logic          rd,
    input  logic [W-1:0]  cnt,
    input  logic          ovf,
    output logic [DW-1:0] rdata,
    output logic          load,
    output logic [W-1:0]  load_val,
    output logic          ovf_clr
);
    typedef struct packed {
        logic [DW-1:0] temp;
        logic [DW-1:0] rdata;
    } bus_s;

    bus_s bus_d, bus_q;

    always_comb begin
        bus_d    = bus_q;
        load     = wr && (addr == ADDR_LO);
        load_val = {bus_q.temp, wdata};
        ovf_clr  = wr && (addr == ADDR_FLG) && wdata[0];
        if (wr && addr == ADDR_HI) bus_d.temp = wdata;
        if (rd) begin
            case (addr)
                ADDR_LO: begin
                    bus_d.rdata = cnt[DW-1:0];
                    bus_d.temp  = cnt[W-1:DW];
                end
                ADDR_HI:  bus_d.rdata = bus_q.temp;
                ADDR_FLG: bus_d.rdata = {{(DW-1){1'b0}}, ovf};
                default:  bus_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign rdata = bus_q.rdata;

    // R2
    lo_read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == ADDR_LO) |=> (bus_q.temp == $past(cnt[W-1:DW]) && rdata == $past(cnt[DW-1:0])));

    // R3
    hi_write_temp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_HI) |=> (bus_q.temp == $past(wdata)));

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));
endmodule

// File: rtl/tcnt_core.sv
module tcnt_core
    import tcnt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr,
    input  logic         dir,
    input  logic [1:0]   mode,
    input  logic [W-1:0] match_top,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         ovf_clr,
    output logic [W-1:0] cnt,
    output logic         at_top,
    output logic         at_bottom,
    output logic         ovf
);
    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         ovf;
    } core_s;

    core_s     core_d, core_q;
    cnt_mode_e md;
    logic [W-1:0] top_val, step;
    logic         ovf_hit;

    always_comb begin
        md      = cnt_mode_e'(mode);
        top_val = (md == MODE_MATCH || md == MODE_UPDN) ? match_top : ALL_ONES;
        if (dir) step = (core_q.cnt == '0) ? top_val : core_q.cnt - ONE;
        else     step = (core_q.cnt == top_val) ? '0 : core_q.cnt + ONE;

        core_d  = core_q;
        ovf_hit = 1'b0;
        if (load) begin
            core_d.cnt = load_val;
        end else if (tick) begin
            if (clr) begin
                core_d.cnt = '0;
            end else begin
                core_d.cnt = step;
                if (md == MODE_UPDN) ovf_hit = (step == '0) && (core_q.cnt != '0);
                else                 ovf_hit = !dir && (core_q.cnt == top_val);
            end
        end
        if (ovf_clr) core_d.ovf = 1'b0;
        if (ovf_hit) core_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign cnt       = core_q.cnt;
    assign ovf       = core_q.ovf;
    assign at_top    = (core_q.cnt == top_val);
    assign at_bottom = (core_q.cnt == '0);

    // R4
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt));

    // R8
    tick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && clr) |=> (cnt == '0));

    // R11
    match_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && !clr && !dir && mode == MODE_MATCH && at_top) |=> (cnt == '0 && ovf));

    // R12
    ovf_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick || load) |=> !$rose(ovf));
endmodule

// File: rtl/bytebus_tick_counter.sv
module bytebus_tick_counter
    import tcnt_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NTAP = 4,
    localparam int W   = 2 * DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic            bus_wr,
    input  logic            bus_rd,
    output logic [DW-1:0]   bus_rdata,
    input  logic [2:0]      clk_sel,
    input  logic [NTAP-1:0] pre_tap,
    input  logic            ext_pin,
    input  logic            cnt_dir,
    input  logic            cnt_clr,
    input  logic [1:0]      cnt_mode,
    input  logic [W-1:0]    match_top,
    output logic [W-1:0]    count,
    output logic            at_top,
    output logic            at_bottom,
    output logic            ovf_flag
);
    logic         tick, load, ovf_clr;
    logic [W-1:0] load_val;

    tcnt_tick_sel #(.NTAP(NTAP)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (clk_sel),
        .taps    (pre_tap),
        .ext_pin (ext_pin),
        .tick    (tick)
    );

    tcnt_bus #(.DW(DW)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .cnt      (count),
        .ovf      (ovf_flag),
        .rdata    (bus_rdata),
        .load     (load),
        .load_val (load_val),
        .ovf_clr  (ovf_clr)
    );

    tcnt_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .clr       (cnt_clr),
        .dir       (cnt_dir),
        .mode      (cnt_mode),
        .match_top (match_top),
        .load      (load),
        .load_val  (load_val),
        .ovf_clr   (ovf_clr),
        .cnt       (count),
        .at_top    (at_top),
        .at_bottom (at_bottom),
        .ovf       (ovf_flag)
    );

    // R3
    hi_write_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_HI && !tick) |=> (count == $past(count)));

    // R2
    no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
endmodule

// File: tb/bytebus_tick_counter_bench.sv
module bytebus_tick_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [2:0]  clk_sel = '0;
    logic [3:0]  pre_tap = '0;
    logic        ext_pin = 1'b0;
    logic        cnt_dir = 1'b0, cnt_clr = 1'b0;
    logic [1:0]  cnt_mode = '0;
    logic [15:0] match_top = 16'h0010;
    logic [15:0] count;
    logic        at_top, at_bottom, ovf_flag;

    int nvec = 0;
    int nerr = 0;
    bit chk_on = 1'b0;

    always #5 clk = ~clk;

    bytebus_tick_counter u_bytebus_tick_counter (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .clk_sel(clk_sel),
        .pre_tap(pre_tap), .ext_pin(ext_pin), .cnt_dir(cnt_dir), .cnt_clr(cnt_clr),
        .cnt_mode(cnt_mode), .match_top(match_top), .count(count), .at_top(at_top),
        .at_bottom(at_bottom), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] top_of(input logic [1:0] m, input logic [15:0] mt);
        return (m == 2'd1 || m == 2'd2) ? mt : 16'hFFFF;
    endfunction

    // Reference state built from the requirements
    logic [15:0] m_cnt;
    logic [7:0]  m_tmp, m_rd;
    logic        m_ovf, e1, e2, e3;

    always @(posedge clk or negedge rst_n) begin : mdl
        logic [15:0] tp, nx;
        logic        tk, hit;
        if (!rst_n) begin
            m_cnt <= '0; m_tmp <= '0; m_rd <= '0; m_ovf <= 1'b0;
            e1 <= 1'b0; e2 <= 1'b0; e3 <= 1'b0;
        end else begin
            tp = top_of(cnt_mode, match_top);
            case (clk_sel)
                3'd0: tk = 1'b0;
                3'd1: tk = 1'b1;
                3'd6: tk = !e2 && e3;
                3'd7: tk = e2 && !e3;
                default: tk = pre_tap[clk_sel - 3'd2];
            endcase
            e1 <= ext_pin; e2 <= e1; e3 <= e2;
            nx = m_cnt; hit = 1'b0;
            if (bus_wr && bus_addr == 2'd0) nx = {m_tmp, bus_wdata};
            else if (tk) begin
                if (cnt_clr) nx = '0;
                else if (cnt_dir) begin
                    nx  = (m_cnt == 16'd0) ? tp : m_cnt - 16'd1;
                    hit = (cnt_mode == 2'd2) && nx == 16'd0 && m_cnt != 16'd0;
                end else begin
                    nx  = (m_cnt == tp) ? 16'd0 : m_cnt + 16'd1;
                    hit = (cnt_mode == 2'd2) ? (nx == 16'd0 && m_cnt != 16'd0) : (m_cnt == tp);
                end
            end
            m_cnt <= nx;
            if (hit) m_ovf <= 1'b1;
            else if (bus_wr && bus_addr == 2'd2 && bus_wdata[0]) m_ovf <= 1'b0;
            if (bus_wr && bus_addr == 2'd1) m_tmp <= bus_wdata;
            if (bus_rd) begin
                case (bus_addr)
                    2'd0: begin m_rd <= m_cnt[7:0]; m_tmp <= m_cnt[15:8]; end
                    2'd1: m_rd <= m_tmp;
                    2'd2: m_rd <= {7'b0, m_ovf};
                    default: m_rd <= 8'h00;
                endcase
            end
        end
    end

    always @(posedge clk) begin
        #2;
        if (rst_n && chk_on) begin
            chk("R9 count vs reference", 32'(count), 32'(m_cnt));
            chk("R10 at_top", 32'(at_top), 32'(m_cnt == top_of(cnt_mode, match_top)));
            chk("R10 at_bottom", 32'(at_bottom), 32'(m_cnt == 16'd0));
            chk("R12 ovf_flag", 32'(ovf_flag), 32'(m_ovf));
            chk("R2 bus_rdata", 32'(bus_rdata), 32'(m_rd));
        end
    end

    task automatic wr_bus(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd_bus(input logic [1:0] a, output logic [7:0] v, output logic [15:0] snap);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0; snap = count;
        @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : wdog
        #2_000_000;
        nerr++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin : main
        logic [7:0]  v;
        logic [15:0] snap, cap;
        int unused_seed;
        unused_seed = $urandom(32'd20250611);
        step(4);
        rst_n = 1'b1;
        chk_on = 1'b1;
        // R1
        chk("R1 count after reset", 32'(count), 32'h0);
        chk("R1 ovf after reset", 32'(ovf_flag), 32'h0);
        chk("R1 rdata after reset", 32'(bus_rdata), 32'h0);
        chk("R1 at_bottom after reset", 32'(at_bottom), 32'h1);
        rd_bus(2'd1, v, snap);
        chk("R1 holding reg after reset", 32'(v), 32'h0);

        // R3: high write does not move the count; low write loads both halves
        wr_bus(2'd1, 8'hAB);
        chk("R3 count after high write", 32'(count), 32'h0);
        wr_bus(2'd0, 8'hCD);
        chk("R3 count after low write", 32'(count), 32'hABCD);

        // R5: stopped source holds
        step(8);
        chk("R5 count held", 32'(count), 32'hABCD);

        // R2: atomic read while running
        wr_bus(2'd1, 8'h12);
        wr_bus(2'd0, 8'hFE);
        clk_sel = 3'd1;
        rd_bus(2'd0, v, cap);
        chk("R2 low byte read", 32'(v), 32'(cap[7:0]));
        step(4);
        rd_bus(2'd1, v, snap);
        chk("R2 high byte from capture", 32'(v), 32'(cap[15:8]));
        chk("R2 counter moved on", 32'(count[15:8]), 32'h13);
        clk_sel = 3'd0;

        // R4: write beats clear+tick
        clk_sel = 3'd1; cnt_clr = 1'b1;
        wr_bus(2'd1, 8'h55);
        wr_bus(2'd0, 8'h66);
        chk("R4 write beats clear", 32'(count), 32'h5566);
        // R8: next tick clears
        step(1);
        chk("R8 tick clear", 32'(count), 32'h0);
        cnt_clr = 1'b0;

        // R9: down wrap from 0 in free mode
        cnt_dir = 1'b1;
        step(1);
        chk("R9 down wrap to TOP", 32'(count), 32'hFFFF);
        step(1);
        chk("R9 down step", 32'(count), 32'hFFFE);
        chk("R12 no ovf on down count in mode 0", 32'(ovf_flag), 32'h0);
        clk_sel = 3'd0; cnt_dir = 1'b0;

        // R6: prescaler tap gating, with a distracting tap held high
        clk_sel = 3'd2;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            pre_tap = (k % 4 == 0) ? 4'b0011 : 4'b0010;
        end
        @(negedge clk); pre_tap = 4'b0000;
        chk("R6 tap0 ticks counted", 32'(count), 32'h0001);
        chk("R12 ovf on up wrap", 32'(ovf_flag), 32'h1);
        clk_sel = 3'd0;

        // R13 and R12 flag read and clear
        rd_bus(2'd2, v, snap);
        chk("R13 flag read", 32'(v), 32'h01);
        wr_bus(2'd2, 8'hFE);
        chk("R12 write of 0 keeps flag", 32'(ovf_flag), 32'h1);
        wr_bus(2'd2, 8'h01);
        chk("R12 write of 1 clears flag", 32'(ovf_flag), 32'h0);
        rd_bus(2'd3, v, snap);
        chk("R2 unused address reads 0", 32'(v), 32'h00);

        // R11 / R10 clear on match
        cnt_mode = 2'd1; match_top = 16'd5;
        wr_bus(2'd1, 8'h00);
        wr_bus(2'd0, 8'h04);
        chk("R10 not at top", 32'(at_top), 32'h0);
        clk_sel = 3'd1;
        step(1);
        chk("R10 at top", 32'(at_top), 32'h1);
        step(1);
        chk("R11 match returns to 0", 32'(count), 32'h0);
        chk("R12 ovf on match wrap", 32'(ovf_flag), 32'h1);
        clk_sel = 3'd0;
        wr_bus(2'd2, 8'h01);

        // R12 up/down mode: reaching bottom sets the flag
        cnt_mode = 2'd2;
        wr_bus(2'd0, 8'h02);
        cnt_dir = 1'b1; clk_sel = 3'd1;
        step(1);
        chk("R12 not yet bottom", 32'(ovf_flag), 32'h0);
        step(1);
        chk("R12 ovf on reaching bottom", 32'(ovf_flag), 32'h1);
        step(1);
        chk("R9 down wrap to match_top", 32'(count), 32'h0005);
        clk_sel = 3'd0; cnt_dir = 1'b0; cnt_mode = 2'd0;
        wr_bus(2'd2, 8'h01);

        // R7 external edges
        wr_bus(2'd1, 8'h01);
        wr_bus(2'd0, 8'h00);
        clk_sel = 3'd7;
        ext_pin = 1'b1;
        step(2);
        chk("R7 not yet counted", 32'(count), 32'h0100);
        step(1);
        chk("R7 rising edge counted", 32'(count), 32'h0101);
        step(4);
        chk("R7 one step per edge", 32'(count), 32'h0101);
        ext_pin = 1'b0;
        step(5);
        chk("R7 falling ignored on rise select", 32'(count), 32'h0101);
        clk_sel = 3'd6;
        ext_pin = 1'b1;
        step(5);
        chk("R7 rising ignored on fall select", 32'(count), 32'h0101);
        ext_pin = 1'b0;
        step(5);
        chk("R7 falling edge counted", 32'(count), 32'h0102);

        // Random phase, checked against the reference every cycle
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            bus_wr = 1'b0; bus_rd = 1'b0;
            if (c % 200 == 0) begin
                clk_sel   = 3'($urandom % 8);
                cnt_mode  = 2'($urandom % 4);
                match_top = 16'(8 + $urandom % 64);
            end
            if ($urandom % 50 == 0) cnt_dir = ~cnt_dir;
            cnt_clr = ($urandom % 50 == 0);
            pre_tap = 4'($urandom & $urandom);
            if ($urandom % 5 == 0) ext_pin = ~ext_pin;
            case ($urandom % 10)
                0: begin
                    bus_wr = 1'b1;
                    bus_addr = 2'($urandom % 4);
                    bus_wdata = (bus_addr == 2'd1 && $urandom % 4 != 0) ? 8'h00 : 8'($urandom);
                end
                1: begin
                    bus_rd = 1'b1;
                    bus_addr = 2'($urandom % 4);
                end
                default: ;
            endcase
        end
        @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
        step(3);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule